// File: doc/BRIEF.md
# Tiny 8-bit Register Processor Core

This block is a small, non-pipelined processor with four 8-bit general registers and a fixed 8-bit instruction word. Each instruction carries a 4-bit opcode in its upper half. The lower half holds either two 2-bit register selectors, a 4-bit immediate, or a register selector paired with a 2-bit skip distance. The core executes shifts, logic, add and unsigned compare. It also executes byte loads and stores, half-byte immediate loads into register 0, a register jump that saves the return address, a branch on zero, and short relative jumps forward and backward.

The core has two memory ports. The instruction port carries only an address and returns read data one clock after that address has been sampled. Instructions can therefore sit in a ROM that is kept apart from data. The data port has address, read data, write data and a write strobe, and it is active only for loads and stores. Both ports expect a synchronous read with a latency of one cycle. Every instruction takes two cycles, fetch and execute, and a load takes a third cycle to capture the data it reads.

Top module: `tiny8_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter and all four registers to zero. While in reset and on release, `imem_addr` is 0 and `dmem_we` is low.
- R2: Bits [7:4] of an instruction are the opcode. Bits [3:2] select register a and bits [1:0] select register b. Register codes 0 to 3 name r0 to r3.
- R3: Opcodes 0x0 to 0x7 write to register a the following results: a shifted left by b, a shifted right by b, NOT b, a AND b, a OR b, a XOR b, a+b, and 1 if a<b else 0. Shifts are logical and give 0 for any amount of 8 or more. The add drops its carry, and the compare is unsigned.
- R4: Opcode 0x8 puts the value of b on `dmem_addr` and writes the byte read from there into a.
- R5: Opcode 0x9 drives `dmem_addr` with a and `dmem_wdata` with b, and holds `dmem_we` high for exactly one cycle.
- R6: Opcode 0xA writes the 4-bit immediate (bits [3:0]) into r0[3:0], and opcode 0xB writes it into r0[7:4]. The other half of r0 is kept in both cases.
- R7: Opcode 0xC loads the PC with the value of b and writes the old PC+1 into a. When a and b are the same register, the jump target is the value b held before the write.
- R8: Opcode 0xD tests register a (bits [3:2]). If a is nonzero the next PC is PC+1. If a is zero the next PC is PC+1+k, where k is bits [1:0].
- R9: Opcode 0xE sets the PC to PC+1+imm, and opcode 0xF sets it to PC−1−imm, where imm is bits [3:0]. All PC arithmetic wraps modulo 256.
- R10: `imem_addr` always shows the PC. A non-load instruction takes one fetch cycle and one execute cycle. A load takes one more cycle, and the PC stays fixed for that cycle.
- R11: `dmem_we` is low during every instruction other than a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Instruction fetch address (current PC) |
| imem_rdata | input | 8 | Instruction byte, valid one cycle after the address is sampled |
| dmem_addr | output | 8 | Data port address for a load or a store |
| dmem_rdata | input | 8 | Data port read byte, one cycle latency |
| dmem_wdata | output | 8 | Data port write byte |
| dmem_we | output | 1 | Data port write strobe, one cycle per store |

## Verification
The ALU opcodes are driven with operand pairs from a seeded random source, mixed with directed pairs. The directed pairs cover shifts of exactly 7 and 8, an add that wraps past 255, an equal compare and an unsigned compare against 0xFF. Together they separate logical from arithmetic shifts, a saturating shift from one that wraps its amount, and signed from unsigned compares. For control flow, each program places poison instructions on the path that a wrong decision would take, and these corrupt the value the program later stores. One short program each checks a taken branch, an untaken branch, a register jump and the wrap from address 0 back to 255. Cycle counts up to the first store show whether a load costs one extra cycle and a plain instruction none.

// File: rtl/tiny8_pkg.sv
package tiny8_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OP_SHL   = 4'h0,
      OP_SHR   = 4'h1,
      OP_INV   = 4'h2,
      OP_AND   = 4'h3,
      OP_OR    = 4'h4,
      OP_XOR   = 4'h5,
      OP_ADD   = 4'h6,
      OP_LTU   = 4'h7,
      OP_LD    = 4'h8,
      OP_ST    = 4'h9,
      OP_SETLO = 4'hA,
      OP_SETHI = 4'hB,
      OP_JREG  = 4'hC,
      OP_BRZ   = 4'hD,
      OP_JFWD  = 4'hE,
      OP_JBWD  = 4'hF
   } opc_e;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_EXEC  = 2'd1,
      PH_LOAD  = 2'd2
   } phase_e;

endpackage

// File: rtl/tiny8_regfile.sv
module tiny8_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 4,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx_a,
   input  logic [IDX_W-1:0]  rd_idx_b,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b
);

   logic [NREG-1:0][DATA_W-1:0] bank;

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         logic [DATA_W-1:0] q;
         logic              hit;

         assign hit = wr_en && (wr_idx == IDX_W'(g));

         always_ff @(posedge clk) begin
            if (rst) begin
               q <= '0;
            end else if (hit) begin
               q <= (q & ~wr_mask) | (wr_data & wr_mask);
            end
         end

         assign bank[g] = q;
      end
   endgenerate

   assign rd_a = bank[rd_idx_a];
   assign rd_b = bank[rd_idx_b];

endmodule

// File: rtl/tiny8_alu.sv
module tiny8_alu #(
   parameter int DATA_W      = 8,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [2:0]        fn,
   output logic [DATA_W-1:0] y
);

   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] shl_v;
   logic [DATA_W-1:0] shr_v;
   logic              lt;

   generate
      if (SHIFT_STYLE != 0 && SHIFT_STYLE != 1) begin : g_bad_style
         $error("tiny8_alu: SHIFT_STYLE must be 0 or 1");
      end

      if (SHIFT_STYLE == 0) begin : g_native
         // Operator shift: any amount of DATA_W or more clears the result.
         assign shl_v = a << b;
         assign shr_v = a >> b;
      end else begin : g_barrel
         // Log-stage shifter; the upper amount bits force zero.
         logic [DATA_W-1:0] lv;
         logic [DATA_W-1:0] rv;
         logic              big;

         assign big = |b[DATA_W-1:SH_W];

         always_comb begin
            lv = a;
            rv = a;
            for (int s = 0; s < SH_W; s++) begin
               if (b[s]) begin
                  lv = lv << (1 << s);
                  rv = rv >> (1 << s);
               end
            end
         end

         assign shl_v = big ? '0 : lv;
         assign shr_v = big ? '0 : rv;
      end
   endgenerate

   assign lt = (a < b);

   always_comb begin
      unique case (fn)
         3'd0:    y = shl_v;
         3'd1:    y = shr_v;
         3'd2:    y = ~b;
         3'd3:    y = a & b;
         3'd4:    y = a | b;
         3'd5:    y = a ^ b;
         3'd6:    y = a + b;
         default: y = {{(DATA_W-1){1'b0}}, lt};
      endcase
   end

endmodule

// File: rtl/tiny8_pcnext.sv
module tiny8_pcnext import tiny8_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int IMM_W  = 4,
   parameter int SIMM_W = 2
) (
   input  opc_e              op,
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] a_val,
   input  logic [DATA_W-1:0] b_val,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] seq,
   output logic [DATA_W-1:0] nxt
);

   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] skip_ext;

   assign imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm};
   assign skip_ext = {{(DATA_W-SIMM_W){1'b0}}, imm[SIMM_W-1:0]};
   assign seq      = pc + DATA_W'(1);

   always_comb begin
      case (op)
         OP_JREG: nxt = b_val;
         OP_BRZ:  nxt = (a_val == '0) ? (seq + skip_ext) : seq;
         OP_JFWD: nxt = seq + imm_ext;
         OP_JBWD: nxt = pc - DATA_W'(1) - imm_ext;
         default: nxt = seq;
      endcase
   end

endmodule

// File: rtl/tiny8_core.sv
module tiny8_core import tiny8_pkg::*; #(
   parameter int DATA_W      = 8,
   parameter int NREG        = 4,
   parameter int SHIFT_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   output logic [DATA_W-1:0] imem_addr,
   input  logic [DATA_W-1:0] imem_rdata,
   output logic [DATA_W-1:0] dmem_addr,
   input  logic [DATA_W-1:0] dmem_rdata,
   output logic [DATA_W-1:0] dmem_wdata,
   output logic              dmem_we
);

   localparam int IDX_W  = $clog2(NREG);
   localparam int IMM_W  = DATA_W - OPC_W;
   localparam int NIB    = DATA_W / 2;
   localparam int SIMM_W = IDX_W;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("tiny8_core: the instruction format needs DATA_W == 8");
      end
      if (NREG != 4) begin : g_bad_nreg
         $error("tiny8_core: two-bit register fields need NREG == 4");
      end
      if (IMM_W != NIB) begin : g_bad_imm
         $error("tiny8_core: immediate must fill half a register");
      end
   endgenerate

   // Decode fields
   opc_e             op;
   logic [IDX_W-1:0] fa;
   logic [IDX_W-1:0] fb;
   logic [IMM_W-1:0] imm;

   assign op  = opc_e'(imem_rdata[DATA_W-1 -: OPC_W]);
   assign fa  = imem_rdata[2*IDX_W-1 -: IDX_W];
   assign fb  = imem_rdata[IDX_W-1:0];
   assign imm = imem_rdata[IMM_W-1:0];

   // Sequencing state
   phase_e            phase_q, phase_d;
   logic [DATA_W-1:0] pc_q, pc_d;

   // Register file wiring
   logic              rf_we;
   logic [IDX_W-1:0]  rf_widx;
   logic [DATA_W-1:0] rf_wmask;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] ra;
   logic [DATA_W-1:0] rb;

   logic [DATA_W-1:0] alu_y;
   logic [DATA_W-1:0] pc_seq;
   logic [DATA_W-1:0] pc_nxt;

   tiny8_regfile #(
      .DATA_W (DATA_W),
      .NREG   (NREG)
   ) u_rf (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (rf_we),
      .wr_idx   (rf_widx),
      .wr_mask  (rf_wmask),
      .wr_data  (rf_wdata),
      .rd_idx_a (fa),
      .rd_idx_b (fb),
      .rd_a     (ra),
      .rd_b     (rb)
   );

   tiny8_alu #(
      .DATA_W      (DATA_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_alu (
      .a  (ra),
      .b  (rb),
      .fn (imem_rdata[DATA_W-OPC_W+2 : DATA_W-OPC_W]),
      .y  (alu_y)
   );

   tiny8_pcnext #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W),
      .SIMM_W (SIMM_W)
   ) u_pcn (
      .op    (op),
      .pc    (pc_q),
      .a_val (ra),
      .b_val (rb),
      .imm   (imm),
      .seq   (pc_seq),
      .nxt   (pc_nxt)
   );

   always_comb begin
      phase_d  = phase_q;
      pc_d     = pc_q;
      rf_we    = 1'b0;
      rf_widx  = fa;
      rf_wmask = '1;
      rf_wdata = alu_y;

      unique case (phase_q)
         PH_FETCH: begin
            phase_d = PH_EXEC;
         end

         PH_EXEC: begin
            phase_d = PH_FETCH;
            pc_d    = pc_nxt;
            case (op)
               OP_LD: begin
                  phase_d = PH_LOAD;
                  pc_d    = pc_q;
               end
               OP_ST, OP_BRZ, OP_JFWD, OP_JBWD: begin
                  rf_we = 1'b0;
               end
               OP_SETLO: begin
                  rf_we    = 1'b1;
                  rf_widx  = '0;
                  rf_wmask = {{NIB{1'b0}}, {NIB{1'b1}}};
                  rf_wdata = {2{imm}};
               end
               OP_SETHI: begin
                  rf_we    = 1'b1;
                  rf_widx  = '0;
                  rf_wmask = {{NIB{1'b1}}, {NIB{1'b0}}};
                  rf_wdata = {2{imm}};
               end
               OP_JREG: begin
                  rf_we    = 1'b1;
                  rf_wdata = pc_seq;
               end
               default: begin
                  rf_we = 1'b1;
               end
            endcase
         end

         PH_LOAD: begin
            rf_we    = 1'b1;
            rf_wdata = dmem_rdata;
            pc_d     = pc_seq;
            phase_d  = PH_FETCH;
         end

         default: begin
            phase_d = PH_FETCH;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_FETCH;
         pc_q    <= '0;
      end else begin
         phase_q <= phase_d;
         pc_q    <= pc_d;
      end
   end

   assign imem_addr  = pc_q;
   assign dmem_addr  = (op == OP_LD) ? rb : ra;
   assign dmem_wdata = rb;
   assign dmem_we    = (phase_q == PH_EXEC) && (op == OP_ST);

endmodule

// File: rtl/tiny8_core_chk.sv
module tiny8_core_chk import tiny8_pkg::*; #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input phase_e            phase,
   input logic [DATA_W-1:0] imem_addr,
   input logic [DATA_W-1:0] imem_rdata,
   input logic              dmem_we
);

   logic [3:0] opc;
   assign opc = imem_rdata[DATA_W-1 -: 4];

   // R1: on leaving reset the fetch starts at address zero
   a_r1_reset_fetch0: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (imem_addr == '0 && phase == PH_FETCH));

   // R5: a store strobe never spans two cycles
   a_r5_we_single: assert property (@(posedge clk) disable iff (rst)
      dmem_we |=> !dmem_we);

   // R11: strobe only while a store executes
   a_r11_we_only_store: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (phase == PH_EXEC && opc == 4'h9));

   // R10: after a store the PC steps by one and fetch resumes
   a_r10_store_advance: assert property (@(posedge clk) disable iff (rst)
      dmem_we |=> (phase == PH_FETCH && imem_addr == $past(imem_addr) + DATA_W'(1)));

   // R10: fetch is followed by execute with the address held
   a_r10_fetch_exec: assert property (@(posedge clk) disable iff (rst)
      phase == PH_FETCH |=> (phase == PH_EXEC && $stable(imem_addr)));

   // R4: a load spends an extra cycle with the PC held
   a_r4_load_hold: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && opc == 4'h8) |=> (phase == PH_LOAD && $stable(imem_addr)));

   // R9: forward relative jump
   a_r9_jump_fwd: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && opc == 4'hE) |=>
         (imem_addr == $past(imem_addr) + DATA_W'(1) + {{(DATA_W-4){1'b0}}, $past(imem_rdata[3:0])}));

   // R9: backward relative jump
   a_r9_jump_bwd: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && opc == 4'hF) |=>
         (imem_addr == $past(imem_addr) - DATA_W'(1) - {{(DATA_W-4){1'b0}}, $past(imem_rdata[3:0])}));

endmodule

bind tiny8_core tiny8_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .phase      (phase_q),
   .imem_addr  (imem_addr),
   .imem_rdata (imem_rdata),
   .dmem_we    (dmem_we)
);

// File: tb/tiny8_core_bench.sv
module tiny8_core_bench;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
   logic       dmem_we;

   logic [7:0] imem [0:255];
   logic [7:0] dmem [0:255];
   logic [7:0] wl_addr [0:15];
   logic [7:0] wl_data [0:15];
   int         wcnt;
   int         cyc;
   int         first_we_cyc;
   logic       seen_top;
   logic [7:0] preset_addr = 8'h80;
   logic [7:0] preset_val  = 8'h00;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   tiny8_core u_tiny8_core (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_rdata (dmem_rdata),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we)
   );

   // Synchronous dual-port memory model with a write log
   always @(posedge clk) begin
      imem_rdata <= imem[imem_addr];
      dmem_rdata <= dmem[dmem_addr];
      if (rst) begin
         cyc      <= 0;
         wcnt     <= 0;
         seen_top <= 1'b0;
         dmem[preset_addr] <= preset_val;
      end else begin
         cyc <= cyc + 1;
         if (imem_addr == 8'hFF) seen_top <= 1'b1;
         if (dmem_we) begin
            dmem[dmem_addr] <= dmem_wdata;
            if (wcnt < 16) begin
               wl_addr[wcnt] <= dmem_addr;
               wl_data[wcnt] <= dmem_wdata;
            end
            if (wcnt == 0) first_we_cyc <= cyc;
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] alu_ref(input logic [2:0] f, input logic [7:0] a, input logic [7:0] b);
      case (f)
         3'd0:    return (b >= 8) ? 8'h00 : 8'(a << b[2:0]);
         3'd1:    return (b >= 8) ? 8'h00 : 8'(a >> b[2:0]);
         3'd2:    return ~b;
         3'd3:    return a & b;
         3'd4:    return a | b;
         3'd5:    return a ^ b;
         3'd6:    return 8'(a + b);
         default: return (a < b) ? 8'h01 : 8'h00;
      endcase
   endfunction

   task automatic clear_prog();
      for (int i = 0; i < 256; i++) imem[i] = 8'h00;
   endtask

   task automatic run_prog(input bit check_reset);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (check_reset) begin
         chk("R1 fetch address in reset", imem_addr, 8'h00);
      end
      rst = 1'b0;
      #1;
      if (check_reset) begin
         chk("R1 fetch address on release", imem_addr, 8'h00);
         chk("R1 write strobe low", {7'd0, dmem_we}, 8'h00);
      end
      repeat (60) @(posedge clk);
      @(negedge clk);
   endtask

   // ALU trial: r1=a, r2=b, r1 = op(r1,r2), store r1 to address 0 (r3 is 0)
   task automatic alu_trial(input logic [2:0] f, input logic [7:0] av, input logic [7:0] bv);
      clear_prog();
      imem[0] = {4'hA, av[3:0]};
      imem[1] = {4'hB, av[7:4]};
      imem[2] = 8'h44;
      imem[3] = {4'hA, bv[3:0]};
      imem[4] = {4'hB, bv[7:4]};
      imem[5] = 8'h48;
      imem[6] = {1'b0, f, 4'b0110};
      imem[7] = 8'h9D;
      imem[8] = 8'hE0;
      imem[9] = 8'hF0;
      run_prog(1'b0);
      chk($sformatf("R3 op%0d a=%0h b=%0h", f, av, bv), wl_data[0], alu_ref(f, av, bv));
      chk("R5 store address", wl_addr[0], 8'h00);
      chk("R5 one strobe per store", 8'(wcnt), 8'd1);
      chk("R10 cycles to store", 8'(first_we_cyc), 8'd15);
   endtask

   task automatic run_all();
      void'($urandom(32'd20240611));

      // R1 reset state, then R6 nibble immediates
      clear_prog();
      imem[0] = 8'hA5; imem[1] = 8'hB3; imem[2] = 8'hA9; imem[3] = 8'h9C;
      imem[4] = 8'hBC; imem[5] = 8'h9C; imem[6] = 8'hE0; imem[7] = 8'hF0;
      run_prog(1'b1);
      chk("R6 low nibble keeps high", wl_data[0], 8'h39);
      chk("R6 high nibble keeps low", wl_data[1], 8'hC9);
      chk("R11 only stores strobe", 8'(wcnt), 8'd2);

      // R4 load from address held in b, plus load timing
      clear_prog();
      preset_addr = 8'h05; preset_val = 8'h3C;
      imem[0] = 8'hA5; imem[1] = 8'h84; imem[2] = 8'h9D; imem[3] = 8'hE0; imem[4] = 8'hF0;
      run_prog(1'b0);
      chk("R4 loaded byte", wl_data[0], 8'h3C);
      chk("R10 load adds one cycle", 8'(first_we_cyc), 8'd6);
      preset_addr = 8'h80; preset_val = 8'h00;

      // R7 register jump skipping poison, link written to a
      clear_prog();
      imem[0] = 8'hA6; imem[1] = 8'hC8;
      for (int i = 2; i < 6; i++) imem[i] = 8'hBF;
      imem[6] = 8'h9E; imem[7] = 8'h98; imem[8] = 8'hE0; imem[9] = 8'hF0;
      run_prog(1'b0);
      chk("R7 link value", wl_data[0], 8'h02);
      chk("R7 target reached without poison", wl_data[1], 8'h06);
      chk("R5 store address from a", wl_addr[1], 8'h02);

      // R1 registers cleared by reset (r2 held 2 before)
      clear_prog();
      imem[0] = 8'h9E; imem[1] = 8'hE0; imem[2] = 8'hF0;
      run_prog(1'b0);
      chk("R1 register cleared", wl_data[0], 8'h00);
      chk("R1 address register cleared", wl_addr[0], 8'h00);

      // R8 branch on zero: taken, then not taken
      clear_prog();
      imem[0] = 8'hD6; imem[1] = 8'hBF; imem[2] = 8'hBF; imem[3] = 8'hA7;
      imem[4] = 8'hD3; imem[5] = 8'h9C; imem[6] = 8'hE0; imem[7] = 8'hF0;
      imem[8] = 8'h9F;
      run_prog(1'b0);
      chk("R8 taken and untaken branch", wl_data[0], 8'h07);
      chk("R8 single store path", 8'(wcnt), 8'd1);

      // R9 backward jump wraps below zero, forward jump wraps past 255
      clear_prog();
      imem[0] = 8'hF0; imem[255] = 8'hE1; imem[1] = 8'hA9; imem[2] = 8'h9C;
      imem[3] = 8'hE0; imem[4] = 8'hF0;
      run_prog(1'b0);
      chk("R9 wrap through 255", wl_data[0], 8'h09);
      chk("R9 fetched address 255", {7'd0, seen_top}, 8'h01);

      // R3 directed corners
      alu_trial(3'd0, 8'h81, 8'h07);
      alu_trial(3'd0, 8'hFF, 8'h08);
      alu_trial(3'd1, 8'h80, 8'h07);
      alu_trial(3'd1, 8'hFF, 8'hF0);
      alu_trial(3'd6, 8'hFF, 8'h01);
      alu_trial(3'd7, 8'h33, 8'h33);
      alu_trial(3'd7, 8'h02, 8'h03);
      alu_trial(3'd7, 8'hFF, 8'h01);
      alu_trial(3'd2, 8'h12, 8'h5A);

      // R3 constrained random
      for (int t = 0; t < 150; t++) begin
         logic [7:0] ra_v, rb_v;
         logic [2:0] f_v;
         f_v  = 3'($urandom);
         ra_v = 8'($urandom);
         rb_v = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
         alu_trial(f_v, ra_v, rb_v);
      end
   endtask

   initial begin
      fork
         begin
            run_all();
         end
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL R10 watchdog expired act=running exp=finished");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule